// File: doc/BRIEF.md
# Tiny 24-bit-Instruction Processor Core

This block is a small 8-bit processor that runs fixed-width 24-bit instruction words from a word-addressed program memory. Each word holds an opcode byte in bits 23:16, operand A in bits 15:8 and operand B in bits 7:0. The core runs one instruction per clock. On each instruction it either moves a byte into a register, runs an ALU operation into the accumulator with an optional inverted result, or changes the program counter through an unconditional or a zero-testing jump. A few fixed opcodes are special: one blinks a debug light, one sounds a beeper, one halts the core, and two do nothing, one quickly and one slowly.

The program memory sits outside the block and answers combinationally. The core presents the program counter on `imem_addr_o` and executes the word on `imem_data_i` at the next rising clock edge. The accumulator is brought out so that the effect of each program can be seen. Reset is an active-low asynchronous input, and the core releases it internally on the clock.

Top module: `tiny24_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the fetch address is 0, the accumulator is 0, and the halt, light and beep outputs are 0.
- R2: Every instruction except NOP, HLT or a taken jump advances the fetch address by one on its execute edge, and address 255 wraps to 0.
- R3: An opcode with bit 7 set is an ALU operation. Bits 7:3 pick the operation: 11000 is A+B, 10100 is A-B (modulo 256), 11100 is OR, 10010 is XOR and 11010 is AND. The result is written to the accumulator.
- R4: When bit 2 of an ALU opcode is 1, the bitwise complement of the ALU result is stored in the accumulator instead of the result.
- R5: In ALU and MOV opcodes, bit 1 set means A is a register address and bit 0 set means B is a register address. A clear bit means the operand is an immediate byte. The eight registers have addresses 0x40 to 0x47, and 0x40 is the accumulator.
- R6: Opcode bits 7:2 = 010000 is MOV. It writes the value of A into the register addressed by B. A MOV with bit 0 clear writes nothing and acts as NUL.
- R7: Opcode bits 7:2 = 011000 is an unconditional jump to the value of A. Bit 1 selects whether A is a register or an immediate.
- R8: Opcode bits 7:2 = 000100 (A nonzero), 010100 (A > 0, signed), 001100 (A < 0, signed) and 011100 (A = 0) jump to the immediate address in B when the test holds, and otherwise fall through. A is a register when bit 1 is set.
- R9: NOP (0x28) holds the fetch address for 5 clock edges and then advances it by one. NUL (0x00) advances after a single edge.
- R10: DBL (0x08) raises `light_o` and DBB (0x48) raises `beep_o`, each for exactly the one cycle after its execute edge.
- R11: HLT (0x04) sets `halted_o`. From then until reset, the fetch address, the accumulator and both pulse outputs stay frozen.
- R12: An undefined opcode, or a register-flagged operand whose address lies outside 0x40 to 0x47, changes no register and advances the fetch address by one, the same as NUL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 8 | Program counter / instruction fetch address |
| imem_data_i | input | 24 | Instruction word at `imem_addr_o` |
| halted_o | output | 1 | Core has executed HLT |
| light_o | output | 1 | One-cycle debug light pulse |
| beep_o | output | 1 | One-cycle beeper pulse |
| acc_o | output | 8 | Accumulator value |

## Verification
The bench aims at the corner cases that a plausible bug would get wrong. A subtraction that goes below zero must wrap to 0xFE. If the invert bit were dropped, the OR result would show 0x3F instead of 0xC0. A MOV whose destination flag is clear must leave the accumulator alone, and an unmapped register address must not be read as register 0. The signed jump tests use 0x80: a core that compares unsigned would take the greater-than jump and skip the less-than one. The NOP stall is counted edge by edge, so a stall that is one edge short or long shows up as an early or late fetch address. A jump to 0xFE shows whether the program counter wraps from 255 to 0. A core that did not stop at HLT would keep advancing the address.

// File: rtl/tiny24_pkg.sv
package tiny24_pkg;

  typedef enum logic [3:0] {
    K_NUL, K_NOP, K_MOV, K_ALU, K_JMP, K_JCC, K_DBL, K_DBB, K_HLT
  } kind_e;

  typedef enum logic [2:0] {
    OP_ADD, OP_SUB, OP_OR, OP_XOR, OP_AND
  } alu_e;

  typedef enum logic [1:0] {
    C_NZ, C_GZ, C_LZ, C_EZ
  } cond_e;

  typedef struct packed {
    kind_e kind;
    alu_e  alu;
    cond_e cond;
    logic  inv;
    logic  a_reg;
    logic  b_reg;
  } dec_t;

endpackage

// File: rtl/tiny24_rst_sync.sv
module tiny24_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tiny24_decode.sv
module tiny24_decode
  import tiny24_pkg::*;
(
  input  logic [7:0] opcode_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o = '0;
    if (opcode_i[7]) begin
      dec_o.inv   = opcode_i[2];
      dec_o.a_reg = opcode_i[1];
      dec_o.b_reg = opcode_i[0];
      dec_o.kind  = K_ALU;
      case (opcode_i[7:3])
        5'b11000: dec_o.alu = OP_ADD;
        5'b10100: dec_o.alu = OP_SUB;
        5'b11100: dec_o.alu = OP_OR;
        5'b10010: dec_o.alu = OP_XOR;
        5'b11010: dec_o.alu = OP_AND;
        default:  dec_o = '0;
      endcase
    end else begin
      case (opcode_i[7:2])
        6'b010000: begin
          dec_o.kind  = K_MOV;
          dec_o.a_reg = opcode_i[1];
          dec_o.b_reg = opcode_i[0];
        end
        6'b011000: begin
          dec_o.kind  = K_JMP;
          dec_o.a_reg = opcode_i[1];
        end
        6'b000100: begin dec_o.kind = K_JCC; dec_o.cond = C_NZ; dec_o.a_reg = opcode_i[1]; end
        6'b010100: begin dec_o.kind = K_JCC; dec_o.cond = C_GZ; dec_o.a_reg = opcode_i[1]; end
        6'b001100: begin dec_o.kind = K_JCC; dec_o.cond = C_LZ; dec_o.a_reg = opcode_i[1]; end
        6'b011100: begin dec_o.kind = K_JCC; dec_o.cond = C_EZ; dec_o.a_reg = opcode_i[1]; end
        default: begin
          case (opcode_i)
            8'h28:   dec_o.kind = K_NOP;
            8'h08:   dec_o.kind = K_DBL;
            8'h48:   dec_o.kind = K_DBB;
            8'h04:   dec_o.kind = K_HLT;
            default: dec_o.kind = K_NUL;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/tiny24_alu.sv
module tiny24_alu
  import tiny24_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_e          op_i,
  input  logic          inv_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  logic [DW-1:0] raw;

  always_comb begin
    case (op_i)
      OP_ADD:  raw = a_i + b_i;
      OP_SUB:  raw = a_i - b_i;
      OP_OR:   raw = a_i | b_i;
      OP_XOR:  raw = a_i ^ b_i;
      OP_AND:  raw = a_i & b_i;
      default: raw = '0;
    endcase
    y_o = inv_i ? ~raw : raw;
  end
endmodule

// File: rtl/tiny24_regfile.sv
module tiny24_regfile #(
  parameter int DW    = 8,
  parameter int NREGS = 8,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_a_i,
  input  logic [IW-1:0] ridx_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o,
  output logic [DW-1:0] acc_o
);
  logic [DW-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic en;
    assign en = we_i && (widx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_q[g] <= '0;
      else if (en)  regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[ridx_a_i];
  assign rdata_b_o = regs_q[ridx_b_i];
  assign acc_o     = regs_q[0];
endmodule

// File: rtl/tiny24_core.sv
module tiny24_core
  import tiny24_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter int          NREGS     = 8,
  parameter logic [7:0]  REG_BASE  = 8'h40,
  parameter int          NOP_STALL = 4,
  localparam int         IWID      = 3 * DW,
  localparam int         RIW       = $clog2(NREGS),
  localparam int         SW        = $clog2(NOP_STALL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [AW-1:0]   imem_addr_o,
  input  logic [IWID-1:0] imem_data_i,
  output logic            halted_o,
  output logic            light_o,
  output logic            beep_o,
  output logic [DW-1:0]   acc_o
);
  localparam logic [SW-1:0] STALL_LAST = SW'(NOP_STALL);

  logic          rst_n;
  logic [DW-1:0] opc, opa, opb;
  dec_t          dec;

  logic [AW-1:0] pc_q, pc_d;
  logic          halted_q, halted_d;
  logic [SW-1:0] stall_q, stall_d;
  logic          light_q, light_d, beep_q, beep_d;

  logic          a_valid, b_valid, ops_ok;
  logic [DW-1:0] rd_a, rd_b, a_val, b_val, alu_y;
  logic          we;
  logic [RIW-1:0] widx;
  logic [DW-1:0] wdata;
  logic          take;
  kind_e         kind_eff;

  assign opc = imem_data_i[IWID-1 -: DW];
  assign opa = imem_data_i[2*DW-1 -: DW];
  assign opb = imem_data_i[DW-1:0];

  tiny24_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i), .rst_ni (rst_ni), .rst_no (rst_n)
  );

  tiny24_decode u_dec (.opcode_i(opc), .dec_o(dec));

  tiny24_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .we_i      (we),
    .widx_i    (widx),
    .wdata_i   (wdata),
    .ridx_a_i  (opa[RIW-1:0]),
    .ridx_b_i  (opb[RIW-1:0]),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b),
    .acc_o     (acc_o)
  );

  tiny24_alu #(.DW(DW)) u_alu (
    .op_i (dec.alu), .inv_i (dec.inv), .a_i (a_val), .b_i (b_val), .y_o (alu_y)
  );

  // Operand resolution: register lookup or immediate
  always_comb begin
    a_valid = (opa[DW-1:RIW] == REG_BASE[DW-1:RIW]);
    b_valid = (opb[DW-1:RIW] == REG_BASE[DW-1:RIW]);
    a_val   = dec.a_reg ? rd_a : opa;
    b_val   = dec.b_reg ? rd_b : opb;
    ops_ok  = (!dec.a_reg || a_valid) && (!dec.b_reg || b_valid);
    kind_eff = dec.kind;
    if (!ops_ok) kind_eff = K_NUL;
    if (dec.kind == K_MOV && !dec.b_reg) kind_eff = K_NUL;
  end

  // Jump condition on operand A
  always_comb begin
    case (dec.cond)
      C_NZ:    take = (a_val != '0);
      C_GZ:    take = !a_val[DW-1] && (a_val != '0);
      C_LZ:    take = a_val[DW-1];
      default: take = (a_val == '0);
    endcase
  end

  // Next-state logic
  always_comb begin
    pc_d     = pc_q;
    halted_d = halted_q;
    stall_d  = stall_q;
    light_d  = 1'b0;
    beep_d   = 1'b0;
    we       = 1'b0;
    widx     = '0;
    wdata    = '0;
    if (!halted_q) begin
      pc_d = pc_q + AW'(1);
      case (kind_eff)
        K_NOP: begin
          if (stall_q == STALL_LAST) begin
            stall_d = '0;
          end else begin
            stall_d = stall_q + SW'(1);
            pc_d    = pc_q;
          end
        end
        K_MOV: begin
          we    = 1'b1;
          widx  = opb[RIW-1:0];
          wdata = a_val;
        end
        K_ALU: begin
          we    = 1'b1;
          widx  = '0;
          wdata = alu_y;
        end
        K_JMP:   pc_d = AW'(a_val);
        K_JCC:   if (take) pc_d = AW'(opb);
        K_DBL:   light_d = 1'b1;
        K_DBB:   beep_d  = 1'b1;
        K_HLT: begin
          halted_d = 1'b1;
          pc_d     = pc_q;
        end
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
      stall_q  <= '0;
      light_q  <= 1'b0;
      beep_q   <= 1'b0;
    end else begin
      pc_q     <= pc_d;
      halted_q <= halted_d;
      stall_q  <= stall_d;
      light_q  <= light_d;
      beep_q   <= beep_d;
    end
  end

  assign imem_addr_o = pc_q;
  assign halted_o    = halted_q;
  assign light_o     = light_q;
  assign beep_o      = beep_q;
endmodule

// File: rtl/tiny24_chk.sv
module tiny24_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] imem_addr_o,
  input logic          halted_o,
  input logic          light_o,
  input logic          beep_o,
  input logic [DW-1:0] acc_o
);
  // R11
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  // R11
  halt_addr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(imem_addr_o));
  // R11
  halt_acc_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(acc_o));
  // R11
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (!light_o && !beep_o));
  // R10
  light_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(light_o) |=> !light_o);
  // R10
  beep_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(beep_o) |=> !beep_o);
  // R10
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(light_o && beep_o));
endmodule

bind tiny24_core tiny24_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .imem_addr_o (imem_addr_o),
  .halted_o    (halted_o),
  .light_o     (light_o),
  .beep_o      (beep_o),
  .acc_o       (acc_o)
);

// File: tb/tiny24_core_tb.sv
`timescale 1ns/1ps
module tiny24_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr;
  logic [23:0] data;
  logic        halted, light, beep;
  logic [7:0]  acc;

  logic [23:0] mem [256];
  assign data = mem[addr];

  always #2.5 clk = ~clk;

  tiny24_core u_dut (
    .clk_i (clk), .rst_ni (rst_n), .imem_addr_o (addr), .imem_data_i (data),
    .halted_o (halted), .light_o (light), .beep_o (beep), .acc_o (acc)
  );

  typedef struct {
    logic [7:0] pc;
    logic [7:0] acc;
    logic       h, l, b;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic mon_en = 1'b0;
  logic done   = 1'b0;

  task automatic put(input int a, input logic [7:0] op, input logic [7:0] x, input logic [7:0] y);
    mem[a] = {op, x, y};
  endtask

  task automatic push(input logic [7:0] pc, input logic [7:0] ac, input logic h,
                      input logic l, input logic b, input string tag);
    exp_t e;
    e.pc = pc; e.acc = ac; e.h = h; e.l = l; e.b = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic run();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    mon_en = 1'b1;
    wait (q.size() == 0);
    @(negedge clk);
    mon_en = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (addr !== e.pc || acc !== e.acc || halted !== e.h || light !== e.l || beep !== e.b) begin
        errors++;
        $display("FAIL %s: got pc=%02h acc=%02h h=%b l=%b b=%b, expected pc=%02h acc=%02h h=%b l=%b b=%b",
                 e.tag, addr, acc, halted, light, beep, e.pc, e.acc, e.h, e.l, e.b);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Program 1: MOV, ALU, invert, operand flags, undefined cases, halt
    clear_mem();
    put(0,  8'h41, 8'h05, 8'h41);  // MOV #5 -> r1
    put(1,  8'hC2, 8'h41, 8'h03);  // ADD r1,#3
    put(2,  8'hA2, 8'h40, 8'h0A);  // SUB acc,#10
    put(3,  8'hE4, 8'h0F, 8'h30);  // OR inverted
    put(4,  8'h93, 8'h40, 8'h41);  // XOR acc,r1
    put(5,  8'hD1, 8'hF0, 8'h40);  // AND #F0,acc
    put(6,  8'h43, 8'h40, 8'h42);  // MOV acc -> r2
    put(7,  8'hC2, 8'h10, 8'h01);  // bad register address
    put(8,  8'h40, 8'h11, 8'h40);  // MOV with B flag clear
    put(9,  8'hF8, 8'h00, 8'h00);  // undefined ALU code
    put(10, 8'hC2, 8'h42, 8'h01);  // ADD r2,#1
    put(11, 8'h04, 8'h00, 8'h00);  // HLT
    push(8'd0,  8'h00, 0,0,0, "R1 reset");
    push(8'd1,  8'h00, 0,0,0, "R6 mov to r1");
    push(8'd2,  8'h08, 0,0,0, "R3 R5 add reg+imm");
    push(8'd3,  8'hFE, 0,0,0, "R3 sub wrap");
    push(8'd4,  8'hC0, 0,0,0, "R4 invert");
    push(8'd5,  8'hC5, 0,0,0, "R5 xor reg,reg");
    push(8'd6,  8'hC0, 0,0,0, "R3 and");
    push(8'd7,  8'hC0, 0,0,0, "R6 mov acc to r2");
    push(8'd8,  8'hC0, 0,0,0, "R12 bad reg addr");
    push(8'd9,  8'hC0, 0,0,0, "R6 mov dest flag clear");
    push(8'd10, 8'hC0, 0,0,0, "R12 undefined opcode");
    push(8'd11, 8'hC1, 0,0,0, "R6 r2 readback");
    push(8'd11, 8'hC1, 1,0,0, "R11 halt");
    push(8'd11, 8'hC1, 1,0,0, "R11 halt hold");
    run();

    // Program 2: jumps, pulses, NOP stall, wrap
    clear_mem();
    put(0,   8'h72, 8'h40, 8'h03); // JEZ acc -> 3
    put(1,   8'h04, 8'h00, 8'h00); // HLT
    put(3,   8'hC0, 8'h80, 8'h00); // ADD #80,#0
    put(4,   8'h52, 8'h40, 8'h01); // JGZ acc -> 1
    put(5,   8'h32, 8'h40, 8'h07); // JLZ acc -> 7
    put(7,   8'h10, 8'h00, 8'h01); // JNZ #0 -> 1
    put(8,   8'h08, 8'h00, 8'h00); // DBL
    put(9,   8'h48, 8'h00, 8'h00); // DBB
    put(10,  8'h28, 8'h00, 8'h00); // NOP
    put(11,  8'h50, 8'h01, 8'h0D); // JGZ #1 -> 13
    put(13,  8'h60, 8'hFE, 8'h00); // JMP #FE
    push(8'd0,   8'h00, 0,0,0, "R1 reset again");
    push(8'd3,   8'h00, 0,0,0, "R8 jez taken");
    push(8'd4,   8'h80, 0,0,0, "R3 add imm");
    push(8'd5,   8'h80, 0,0,0, "R8 jgz negative not taken");
    push(8'd7,   8'h80, 0,0,0, "R8 jlz taken");
    push(8'd8,   8'h80, 0,0,0, "R8 jnz zero not taken");
    push(8'd9,   8'h80, 0,1,0, "R10 light pulse");
    push(8'd10,  8'h80, 0,0,1, "R10 beep pulse");
    push(8'd10,  8'h80, 0,0,0, "R9 nop stall 1");
    push(8'd10,  8'h80, 0,0,0, "R9 nop stall 2");
    push(8'd10,  8'h80, 0,0,0, "R9 nop stall 3");
    push(8'd10,  8'h80, 0,0,0, "R9 nop stall 4");
    push(8'd11,  8'h80, 0,0,0, "R9 nop done");
    push(8'd13,  8'h80, 0,0,0, "R8 jgz positive taken");
    push(8'd254, 8'h80, 0,0,0, "R7 jmp imm");
    push(8'd255, 8'h80, 0,0,0, "R9 nul advance");
    push(8'd0,   8'h80, 0,0,0, "R2 pc wrap");
    push(8'd1,   8'h80, 0,0,0, "R8 jez nonzero falls through");
    push(8'd1,   8'h80, 1,0,0, "R11 halt at 1");
    run();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule